// File: doc/BRIEF.md
# Converter Control Register Sequencer

This block is the byte-level control logic that sits behind a two-wire serial interface on a four-input analog converter. A separate bit-level front end hands it whole received bytes plus single-cycle start and stop markers. The first byte after a start is treated as an address: the upper four bits must read 1001 and bits 3:1 must equal the three strap pins. Bit 0 of that byte is the transfer direction. On a match the block requests an acknowledge. On a write, the next byte is stored as the control register. Any further write bytes are acknowledged and passed over without being stored. When the address does not match, every byte is ignored until the next start.

The control register sets the analog-output enable (bit 6), the input mode (bits 5:4), auto-increment (bit 2) and the channel select (bits 1:0). From these the block derives the channel index that the converter uses. A select beyond the last channel of the current mode is clamped to that last channel. With auto-increment on, the index steps after every finished conversion and wraps from the last channel to 0. An oscillator-run output is held high while the analog output is enabled. It is also held high from a conversion request until that conversion completes.

The sequencer is built around one state machine with six states:
- S_IDLE: waiting for a start.
- S_ADDR: expecting the address byte.
- S_CTRL: expecting the control byte.
- S_WDATA: further write bytes, acknowledged and not stored.
- S_READ: read transfer, no acknowledge requests.
- S_SKIP: address mismatch, everything ignored.

Its transitions are:
- Any state goes to S_ADDR on a start, and to S_IDLE on a stop. A start has priority over a stop and over a byte in the same cycle.
- S_ADDR goes to S_CTRL on a matching write address, to S_READ on a matching read address, and to S_SKIP on a mismatch.
- S_CTRL goes to S_WDATA on the control byte.

Top module: `conv_ctrl_seq`

## Requirements
- R1: After reset the stored control register is 0x00, and chan_idx, aout_en, osc_run, ack_req and rd_dir are all 0.
- R2: A byte received in the cycle after a start (state S_ADDR) with bits 7:4 = 1001 and bits 3:1 = pin_addr makes ack_req high for exactly the one cycle that follows the byte. rd_dir then takes bit 0 of that byte (1 = read).
- R3: After a mismatching address byte, that byte and every later byte until the next start leave ack_req low and the control register unchanged.
- R4: In a write transfer, the byte after the address is acknowledged and stored. Later bytes of the same transfer are acknowledged but do not change the register. Bytes of a read transfer are neither acknowledged nor stored.
- R5: Bits 7 and 3 of the stored control register are always 0, whatever value is written. Such a write is still acknowledged.
- R6: On a control write, chan_idx becomes the select field (bits 1:0) clamped to the last channel of the written mode (bits 5:4). The last channel is 3 for mode 0, 2 for modes 1 and 2, and 1 for mode 3.
- R7: With auto-increment (bit 2) set, each conv_done pulse advances chan_idx by one. From the last channel of the current mode it goes to 0.
- R8: With auto-increment clear, conv_done leaves chan_idx unchanged.
- R9: aout_en equals bit 6 of the stored register, and osc_run is high whenever aout_en is high.
- R10: With aout_en low, osc_run goes high the cycle after conv_req and returns low the cycle after conv_done.
- R11: After a stop, bytes arriving before the next start are ignored: no acknowledge and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_addr | input | 3 | Strapped address bits compared with byte bits 3:1 |
| start_seen | input | 1 | One-cycle start marker from front end |
| stop_seen | input | 1 | One-cycle stop marker from front end |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| conv_req | input | 1 | Conversion request pulse |
| conv_done | input | 1 | Conversion completed pulse |
| ack_req | output | 1 | Request to acknowledge the previous byte |
| rd_dir | output | 1 | Direction of the current transfer, 1 = read |
| ctrl_reg | output | 8 | Stored control register |
| aout_en | output | 1 | Analog output enable |
| osc_run | output | 1 | Oscillator run request |
| chan_idx | output | 2 | Active input channel |

## Verification
Several properties are checked on every cycle:
- chan_idx never exceeds the last channel of the current mode.
- The reserved bits stay clear.
- No acknowledge is raised while in S_SKIP.
- ack_req only follows a received byte.
- The channel wraps to 0 after the last channel.
- osc_run follows conversion requests and completions.

The stimulus-driven checks cover the things a single-cycle property cannot express:
- Complete transfers with matching and mismatching addresses.
- Read transfers that must not touch the register.
- Bytes arriving after a stop.
- Sequences of conversions compared against a reference model of clamping and stepping.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    localparam int BYTE_W = 8;
    localparam int PIN_W  = 3;
    localparam int CH_W   = 2;
    localparam int MODE_W = 2;

    localparam logic [3:0]        ADDR_PREFIX = 4'b1001;
    localparam logic [BYTE_W-1:0] RSV_MASK    = 8'h77;

    localparam int BIT_AOUT = 6;
    localparam int BIT_AINC = 2;
    localparam int MODE_LSB = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CTRL,
        S_WDATA,
        S_READ,
        S_SKIP
    } link_state_t;

    function automatic logic [CH_W-1:0] chan_last(input logic [MODE_W-1:0] mode);
        logic [CH_W-1:0] r;
        unique case (mode)
            2'd0:    r = 2'd3;
            2'd1:    r = 2'd2;
            2'd2:    r = 2'd2;
            default: r = 2'd1;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ccs_link_fsm.sv
module ccs_link_fsm
    import ccs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_addr,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              ack_req,
    output logic              rd_dir,
    output logic              ctrl_wr,
    output logic [BYTE_W-1:0] ctrl_q
);
    link_state_t state_q, state_d;
    logic        addr_hit;
    logic        ack_d;

    assign addr_hit = (byte_data[BYTE_W-1:BYTE_W-4] == ADDR_PREFIX) &&
                      (byte_data[PIN_W:1] == pin_addr);

    always_comb begin
        state_d = state_q;
        ack_d   = 1'b0;
        ctrl_wr = 1'b0;
        if (start_seen) begin
            state_d = S_ADDR;
        end else if (stop_seen) begin
            state_d = S_IDLE;
        end else if (byte_valid) begin
            unique case (state_q)
                S_ADDR: begin
                    if (addr_hit) begin
                        ack_d   = 1'b1;
                        state_d = byte_data[0] ? S_READ : S_CTRL;
                    end else begin
                        state_d = S_SKIP;
                    end
                end
                S_CTRL: begin
                    ack_d   = 1'b1;
                    ctrl_wr = 1'b1;
                    state_d = S_WDATA;
                end
                S_WDATA: ack_d = 1'b1;
                S_IDLE, S_READ, S_SKIP: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_req <= 1'b0;
            rd_dir  <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            ack_req <= ack_d;
            if (!start_seen && !stop_seen && byte_valid &&
                state_q == S_ADDR && addr_hit)
                rd_dir <= byte_data[0];
            if (ctrl_wr)
                ctrl_q <= byte_data & RSV_MASK;
        end
    end

    // R3
    skip_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SKIP && !start_seen) |=> !ack_req);

    // R2
    ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> $past(byte_valid));

    // R5
    rsv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] && !ctrl_q[3]);

    // R4
    read_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ && !start_seen) |=> $stable(ctrl_q));
endmodule

// File: rtl/ccs_chan_gen.sv
module ccs_chan_gen
    import ccs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic              cur_ainc,
    input  logic              conv_done,
    output logic [CH_W-1:0]   chan_idx
);
    logic [MODE_W-1:0] wr_mode;
    logic [CH_W-1:0]   wr_sel;
    logic [CH_W-1:0]   wr_last;
    logic [CH_W-1:0]   cur_last;

    assign wr_mode  = wr_data[MODE_LSB +: MODE_W];
    assign wr_sel   = wr_data[CH_W-1:0];
    assign wr_last  = chan_last(wr_mode);
    assign cur_last = chan_last(cur_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_idx <= '0;
        end else if (wr_en) begin
            chan_idx <= (wr_sel > wr_last) ? wr_last : wr_sel;
        end else if (conv_done && cur_ainc) begin
            chan_idx <= (chan_idx >= cur_last) ? '0 : chan_idx + 1'b1;
        end
    end

    // R6
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_idx <= cur_last);

    // R7
    chan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conv_done && cur_ainc && chan_idx == cur_last) |=> chan_idx == '0);

    // R8
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cur_ainc) |=> $stable(chan_idx));
endmodule

// File: rtl/ccs_osc_ctl.sv
module ccs_osc_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic aout_en,
    input  logic conv_req,
    input  logic conv_done,
    output logic osc_run
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (conv_req)  busy_q <= 1'b1;
        else if (conv_done) busy_q <= 1'b0;
    end

    assign osc_run = aout_en | busy_q;

    // R10
    osc_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> osc_run);

    // R10
    osc_off_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !conv_req && !aout_en) ##1 !aout_en |-> !osc_run);
endmodule

// File: rtl/conv_ctrl_seq.sv
module conv_ctrl_seq
    import ccs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_addr,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              conv_req,
    input  logic              conv_done,
    output logic              ack_req,
    output logic              rd_dir,
    output logic [BYTE_W-1:0] ctrl_reg,
    output logic              aout_en,
    output logic              osc_run,
    output logic [CH_W-1:0]   chan_idx
);
    logic ctrl_wr;

    ccs_link_fsm i_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_addr   (pin_addr),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ack_req    (ack_req),
        .rd_dir     (rd_dir),
        .ctrl_wr    (ctrl_wr),
        .ctrl_q     (ctrl_reg)
    );

    ccs_chan_gen i_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .wr_data   (byte_data),
        .cur_mode  (ctrl_reg[MODE_LSB +: MODE_W]),
        .cur_ainc  (ctrl_reg[BIT_AINC]),
        .conv_done (conv_done),
        .chan_idx  (chan_idx)
    );

    assign aout_en = ctrl_reg[BIT_AOUT];

    ccs_osc_ctl i_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .aout_en   (aout_en),
        .conv_req  (conv_req),
        .conv_done (conv_done),
        .osc_run   (osc_run)
    );

    // R9
    aout_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aout_en |-> osc_run);
endmodule

// File: tb/test_conv_ctrl_seq.sv
module test_conv_ctrl_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_addr = 3'b101;
    logic       start_seen = 1'b0, stop_seen = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       conv_req = 1'b0, conv_done = 1'b0;
    logic       ack_req, rd_dir, aout_en, osc_run;
    logic [7:0] ctrl_reg;
    logic [1:0] chan_idx;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_ctrl = 8'h00;
    logic [1:0] m_chan = 2'd0;

    always #5 clk = ~clk;

    conv_ctrl_seq i_conv_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .pin_addr(pin_addr),
        .start_seen(start_seen), .stop_seen(stop_seen),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .conv_req(conv_req), .conv_done(conv_done),
        .ack_req(ack_req), .rd_dir(rd_dir), .ctrl_reg(ctrl_reg),
        .aout_en(aout_en), .osc_run(osc_run), .chan_idx(chan_idx)
    );

    function automatic logic [1:0] last_of(input logic [1:0] mode);
        return (mode == 2'd0) ? 2'd3 : (mode == 2'd3) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [1:0] clamp_sel(input logic [7:0] c);
        return (c[1:0] > last_of(c[5:4])) ? last_of(c[5:4]) : c[1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_seen = 1'b1;
        @(negedge clk) start_seen = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_seen = 1'b1;
        @(negedge clk) stop_seen = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
        @(negedge clk) byte_valid = 1'b0;
        chk(ack_req == exp_ack, req, ack_req, exp_ack);
        chk(ctrl_reg == m_ctrl, req, ctrl_reg, m_ctrl);
        chk(chan_idx == m_chan, req, chan_idx, m_chan);
    endtask

    task automatic write_ctrl(input logic [7:0] c);
        pulse_start();
        send({4'b1001, pin_addr, 1'b0}, 1'b1, "R2");
        chk(rd_dir == 1'b0, "R2", rd_dir, 0);
        m_ctrl = c & 8'h77;
        m_chan = clamp_sel(c);
        send(c, 1'b1, (c & 8'h88) != 0 ? "R5" : "R6");
        chk(aout_en == m_ctrl[6], "R9", aout_en, m_ctrl[6]);
        chk(osc_run == m_ctrl[6], "R9", osc_run, m_ctrl[6]);
    endtask

    task automatic convert(input int gap);
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
        chk(osc_run == 1'b1, "R10", osc_run, 1);
        repeat (gap) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk) conv_done = 1'b0;
        if (m_ctrl[2]) m_chan = (m_chan >= last_of(m_ctrl[5:4])) ? 2'd0 : m_chan + 2'd1;
        chk(osc_run == m_ctrl[6], "R10", osc_run, m_ctrl[6]);
        chk(chan_idx == m_chan, m_ctrl[2] ? "R7" : "R8", chan_idx, m_chan);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(ctrl_reg == 8'h00, "R1", ctrl_reg, 0);
        chk(chan_idx == 2'd0 && aout_en == 1'b0, "R1", {aout_en, chan_idx}, 0);
        chk(osc_run == 1'b0 && ack_req == 1'b0 && rd_dir == 1'b0, "R1",
            {osc_run, ack_req, rd_dir}, 0);
        @(negedge clk) rst_n = 1'b1;

        // reserved bits, mode 3 clamp to 1, auto-inc wrap
        write_ctrl(8'hFF);
        chk(ctrl_reg == 8'h77, "R5", ctrl_reg, 8'h77);
        chk(chan_idx == 2'd1, "R6", chan_idx, 1);
        convert(2);
        chk(chan_idx == 2'd0, "R7", chan_idx, 0);
        // further write byte: acked, not stored
        send(8'h00, 1'b1, "R4");
        pulse_stop();
        // bytes after stop without start
        send({4'b1001, pin_addr, 1'b0}, 1'b0, "R11");
        send(8'h00, 1'b0, "R11");

        // mismatching address
        pulse_start();
        send({4'b1001, pin_addr ^ 3'b011, 1'b0}, 1'b0, "R3");
        send(8'h00, 1'b0, "R3");
        send({4'b1001, pin_addr, 1'b0}, 1'b0, "R3");
        pulse_start();
        send({4'b1000, pin_addr, 1'b0}, 1'b0, "R3");
        pulse_stop();

        // read transfer
        pulse_start();
        send({4'b1001, pin_addr, 1'b1}, 1'b1, "R2");
        chk(rd_dir == 1'b1, "R2", rd_dir, 1);
        send(8'h00, 1'b0, "R4");
        pulse_stop();

        // output disabled: oscillator only during conversion, no auto-inc
        write_ctrl(8'h02);
        convert(3);
        convert(0);
        chk(chan_idx == 2'd2, "R8", chan_idx, 2);
        pulse_stop();

        // mode 1 select 3 clamps to 2, wrap
        write_ctrl(8'h17);
        chk(chan_idx == 2'd2, "R6", chan_idx, 2);
        convert(1);
        convert(1);
        pulse_stop();

        // random transfers
        for (int i = 0; i < 60; i++) begin
            logic [7:0] c;
            pin_addr = 3'($urandom);
            c = 8'($urandom);
            write_ctrl(c);
            for (int k = 0; k < int'($urandom_range(1, 5)); k++)
                convert(int'($urandom_range(0, 3)));
            if ($urandom_range(0, 1) == 1) begin
                pulse_start();
                send({4'b1001, pin_addr ^ 3'($urandom_range(1, 7)), 1'b0}, 1'b0, "R3");
                send(8'($urandom), 1'b0, "R3");
            end
            pulse_stop();
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule